// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block holds the byte queues and interrupt logic of a serial port: a 16-entry transmit queue that software fills and the frame engine drains, a 16-entry receive queue that the frame engine fills and software drains, and two interrupt flags (transmit at bit 0, receive at bit 1) behind a byte-wide register bus. Each flag is raised by hardware on the rising edge of its condition. Software can also force a flag, clear it, and mask it, each through its own register address. A single level interrupt output is the OR of the enabled pending flags.

The receive condition compares the receive fill level against a limit that is half the queue depth plus a 3-bit field. This means the limit can never drop below half the queue. A driver that wants a few waiting bytes serviced forces the receive flag through the set address. The transmit condition is an almost-empty indication. When a queue's mode bit is clear, its condition becomes "any byte present" (receive) or "queue empty" (transmit).

Each queue is controlled by a state machine with the states FIFO_EMPTY, FIFO_PARTIAL and FIFO_FULL:
- FIFO_EMPTY goes to FIFO_PARTIAL on an accepted push.
- FIFO_PARTIAL goes to FIFO_FULL when a push alone fills the last entry.
- FIFO_PARTIAL goes back to FIFO_EMPTY when a pop alone removes the last entry.
- FIFO_FULL goes to FIFO_PARTIAL on a pop.

Each flag is a state machine with the states FLAG_IDLE and FLAG_PENDING:
- FLAG_IDLE goes to FLAG_PENDING on a condition rise or a software set.
- FLAG_PENDING goes to FLAG_IDLE only on a software clear in a cycle with no rise and no set.

Top module: `uart_irq_fifo_ctl`

Register addresses (3-bit `bus_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | data | read pops the receive queue, write pushes the transmit queue |
| 1 | queue status | read only |
| 2 | queue configuration | read and write |
| 4 | flag clear | write 1 to clear |
| 5 | flag set | write 1 to set |
| 6 | interrupt enable | read and write |
| 7 | flag status | read only |

## Requirements
- R1: Both queues hold 16 bytes in first-in first-out order. A write to address 0 pushes the transmit queue, and a write while that queue is full is dropped. A read strobe at address 0 pops the receive queue, whose head byte is shown on `bus_rdata` at address 0. `txq_pop` removes the transmit head shown on `txq_data`, and `txq_avail` is high while the transmit queue is not empty.
- R2: The queue status byte at address 1 shows receive empty in bit 2, receive threshold reached in bit 3, transmit full in bit 4 and transmit almost empty in bit 7. Its other bits read 0.
- R3: The configuration byte at address 2 holds the receive threshold field in bits 2:0, the receive queue mode in bit 3 and the transmit queue mode in bit 7. It reads back those bits and reads 0 elsewhere.
- R4: With the receive mode set, the receive condition is true when the fill level exceeds 8 plus the threshold field. With the mode clear, it is true when the receive queue holds any byte.
- R5: With the transmit mode set, the transmit condition is true when the transmit fill level is at most 8. With the mode clear, it is true when the transmit queue is empty.
- R6: A flag (bit 0 transmit, bit 1 receive, read at address 7) becomes set one cycle after its condition rises. It stays set while the condition stays high or falls, until it is cleared.
- R7: Writing to address 4 clears each flag whose bit is 1 and leaves the other flags unchanged.
- R8: Writing to address 5 sets each flag whose bit is 1, whatever the state of its condition.
- R9: When a clear of a flag and a rise of its condition fall in the same cycle, the flag ends set.
- R10: `irq` is high exactly when some flag is set and its bit in the enable register at address 6 is 1. The enable register reads back in bits 1:0.
- R11: After reset both queues are empty and the configuration and enable registers are 0, so `irq` is low and the status byte reads 0x84. The transmit flag becomes set in the first cycle after reset, because an empty transmit queue is a rising condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive queue at address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| txq_pop | input | 1 | Frame engine takes the transmit head |
| txq_data | output | 8 | Transmit queue head byte |
| txq_avail | output | 1 | Transmit queue not empty |
| rxq_push | input | 1 | Frame engine delivers a received byte |
| rxq_data | input | 8 | Received byte |

## Verification
The queues are filled to the full limit and one beyond it, then drained, so that ordering, dropping of the overflow write, and both fill-level conditions are tested at their exact switching counts. For the receive limit, two threshold fields are used: one catches a missing offset of half the depth, and the other catches a threshold field that is ignored. The flags are driven through four patterns: condition edges, forced sets, selective clears and masking. A clear issued in the very cycle of a condition rise separates set-wins priority from clear-wins priority. A second clear, made while the condition is still high, separates edge triggering from level triggering.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int THR_W      = 3;
    localparam int NUM_IRQ    = 2;

    localparam logic [ADDR_W-1:0] ADDR_DATA     = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_FSTAT    = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_FCFG     = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG_CLR = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_FLAG_SET = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_IRQ_EN   = 3'd6;
    localparam logic [ADDR_W-1:0] ADDR_IRQ_STAT = 3'd7;

    localparam int FS_RX_EMPTY  = 2;
    localparam int FS_RX_ALMOST = 3;
    localparam int FS_TX_FULL   = 4;
    localparam int FS_TX_ALMOST = 7;
    localparam int CFG_RX_MODE  = 3;
    localparam int CFG_TX_MODE  = 7;
    localparam int IRQ_TX       = 0;
    localparam int IRQ_RX       = 1;

    typedef enum logic [1:0] {
        FIFO_EMPTY,
        FIFO_PARTIAL,
        FIFO_FULL
    } fifo_state_e;

    typedef enum logic {
        FLAG_IDLE,
        FLAG_PENDING
    } flag_state_e;

    typedef struct packed {
        logic             tx_mode;
        logic             rx_mode;
        logic [THR_W-1:0] rx_thr;
    } fifo_cfg_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    import uart_irq_pkg::*;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    fifo_state_e      state, state_nxt;
    logic             do_push, do_pop;

    assign do_push = push && (state != FIFO_FULL);
    assign do_pop  = pop  && (state != FIFO_EMPTY);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FIFO_EMPTY;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            FIFO_EMPTY: begin
                if (do_push) state_nxt = (DEPTH == 1) ? FIFO_FULL : FIFO_PARTIAL;
            end
            FIFO_PARTIAL: begin
                if (do_push && !do_pop && count == CNT_W'(DEPTH - 1))
                    state_nxt = FIFO_FULL;
                else if (do_pop && !do_push && count == CNT_W'(1))
                    state_nxt = FIFO_EMPTY;
            end
            FIFO_FULL: begin
                if (do_pop) state_nxt = (DEPTH == 1) ? FIFO_EMPTY : FIFO_PARTIAL;
            end
            default: state_nxt = FIFO_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        empty = (state == FIFO_EMPTY);
        full  = (state == FIFO_FULL);
        head  = mem[rd_ptr];
    end

    // R1: a push into a full queue with no pop leaves the level unchanged
    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

    // R1: a pop from an empty queue with no push leaves the level unchanged
    p_empty_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> $stable(count));

    // R1: the full state agrees with the level counter
    p_state_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/fifo_level_watch.sv
module fifo_level_watch
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int HALF  = DEPTH / 2
) (
    input  fifo_cfg_t        cfg,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_almost,
    output logic             tx_almost_empty
);
    logic [CNT_W-1:0] rx_limit;

    always_comb begin
        rx_limit = CNT_W'(HALF) + CNT_W'(cfg.rx_thr);
        if (cfg.rx_mode) rx_almost = (rx_count > rx_limit);
        else             rx_almost = (rx_count != '0);
        if (cfg.tx_mode) tx_almost_empty = (tx_count <= CNT_W'(HALF));
        else             tx_almost_empty = (tx_count == '0);
    end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic sw_set,
    input  logic sw_clr,
    output logic pending
);
    import uart_irq_pkg::*;

    flag_state_e state, state_nxt;
    logic        cond_q;
    logic        rise;

    assign rise = cond && !cond_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic: a hardware or software set outranks a clear
    always_comb begin
        state_nxt = state;
        unique case (state)
            FLAG_IDLE: begin
                if (rise || sw_set) state_nxt = FLAG_PENDING;
            end
            FLAG_PENDING: begin
                if (sw_clr && !rise && !sw_set) state_nxt = FLAG_IDLE;
            end
            default: state_nxt = FLAG_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pending = (state == FLAG_PENDING);
    end

    // R6: a pending flag with no clear stays pending
    p_hold_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !sw_clr) |=> pending);

    // R9: clear coinciding with a condition rise leaves the flag pending
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !cond_q && sw_clr) |=> pending);

    // R8: a software set always results in a pending flag
    p_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> pending);
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  rx_head,
    input  logic               rx_empty,
    input  logic               rx_almost,
    input  logic               tx_full,
    input  logic               tx_almost_empty,
    input  logic [NUM_IRQ-1:0] flags,
    output logic               tx_push,
    output logic               rx_pop,
    output logic [NUM_IRQ-1:0] flag_set,
    output logic [NUM_IRQ-1:0] flag_clr,
    output fifo_cfg_t          cfg_q,
    output logic [NUM_IRQ-1:0] irq_en
);
    logic [DATA_W-1:0] fstat, fcfg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            irq_en <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_FCFG) begin
                cfg_q.tx_mode <= bus_wdata[CFG_TX_MODE];
                cfg_q.rx_mode <= bus_wdata[CFG_RX_MODE];
                cfg_q.rx_thr  <= bus_wdata[THR_W-1:0];
            end
            if (bus_addr == ADDR_IRQ_EN) begin
                irq_en <= bus_wdata[NUM_IRQ-1:0];
            end
        end
    end

    always_comb begin
        tx_push  = bus_wr && (bus_addr == ADDR_DATA);
        rx_pop   = bus_rd && (bus_addr == ADDR_DATA);
        flag_set = (bus_wr && bus_addr == ADDR_FLAG_SET) ? bus_wdata[NUM_IRQ-1:0] : '0;
        flag_clr = (bus_wr && bus_addr == ADDR_FLAG_CLR) ? bus_wdata[NUM_IRQ-1:0] : '0;
    end

    always_comb begin
        fstat = '0;
        fstat[FS_RX_EMPTY]  = rx_empty;
        fstat[FS_RX_ALMOST] = rx_almost;
        fstat[FS_TX_FULL]   = tx_full;
        fstat[FS_TX_ALMOST] = tx_almost_empty;
        fcfg = '0;
        fcfg[CFG_TX_MODE] = cfg_q.tx_mode;
        fcfg[CFG_RX_MODE] = cfg_q.rx_mode;
        fcfg[THR_W-1:0]   = cfg_q.rx_thr;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA:     bus_rdata = rx_head;
            ADDR_FSTAT:    bus_rdata = fstat;
            ADDR_FCFG:     bus_rdata = fcfg;
            ADDR_IRQ_EN:   bus_rdata = DATA_W'(irq_en);
            ADDR_IRQ_STAT: bus_rdata = DATA_W'(flags);
            default:       bus_rdata = '0;
        endcase
    end

    // R3: configuration fields capture the written bits
    p_cfg_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_FCFG) |=>
            (cfg_q.rx_thr  == $past(bus_wdata[THR_W-1:0]) &&
             cfg_q.rx_mode == $past(bus_wdata[CFG_RX_MODE]) &&
             cfg_q.tx_mode == $past(bus_wdata[CFG_TX_MODE])));
endmodule

// File: rtl/uart_irq_fifo_ctl.sv
module uart_irq_fifo_ctl
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              txq_pop,
    output logic [DATA_W-1:0] txq_data,
    output logic              txq_avail,
    input  logic              rxq_push,
    input  logic [DATA_W-1:0] rxq_data
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [CNT_W-1:0]   tx_count, rx_count;
    logic               tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0]  rx_head;
    logic               tx_push, rx_pop;
    logic               rx_almost, tx_almost_empty;
    logic [NUM_IRQ-1:0] flags, flag_set, flag_clr, irq_en, cond_vec;
    fifo_cfg_t          cfg_q;

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(bus_wdata), .pop(txq_pop),
        .head(txq_data), .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rxq_push), .push_data(rxq_data), .pop(rx_pop),
        .head(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    fifo_level_watch #(.DEPTH(FIFO_DEPTH)) u_watch (
        .cfg(cfg_q), .rx_count(rx_count), .tx_count(tx_count),
        .rx_almost(rx_almost), .tx_almost_empty(tx_almost_empty)
    );

    irq_reg_decode u_decode (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_almost(rx_almost),
        .tx_full(tx_full), .tx_almost_empty(tx_almost_empty),
        .flags(flags), .tx_push(tx_push), .rx_pop(rx_pop),
        .flag_set(flag_set), .flag_clr(flag_clr),
        .cfg_q(cfg_q), .irq_en(irq_en)
    );

    always_comb begin
        cond_vec         = '0;
        cond_vec[IRQ_TX] = tx_almost_empty;
        cond_vec[IRQ_RX] = rx_almost;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
        irq_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .cond(cond_vec[g]), .sw_set(flag_set[g]), .sw_clr(flag_clr[g]),
            .pending(flags[g])
        );
    end

    assign irq       = |(flags & irq_en);
    assign txq_avail = !tx_empty;

    // R10: with every source masked the interrupt line stays low
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    // R1: a full receive queue never reports empty
    p_rx_full_not_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_empty);
endmodule

// File: tb/test_uart_irq_fifo_ctl.sv
module test_uart_irq_fifo_ctl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       txq_pop = 1'b0;
    logic [7:0] txq_data;
    logic       txq_avail;
    logic       rxq_push = 1'b0;
    logic [7:0] rxq_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_fifo_ctl i_uart_irq_fifo_ctl (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .txq_pop(txq_pop), .txq_data(txq_data), .txq_avail(txq_avail),
        .rxq_push(rxq_push), .rxq_data(rxq_data)
    );

    localparam logic [2:0] A_DATA = 3'd0, A_FSTAT = 3'd1, A_FCFG = 3'd2,
                           A_CLR = 3'd4, A_SET = 3'd5, A_EN = 3'd6, A_STAT = 3'd7;

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rx_put(input logic [7:0] d);
        @(negedge clk);
        rxq_push = 1'b1; rxq_data = d;
        @(negedge clk);
        rxq_push = 1'b0;
    endtask

    task automatic rx_take(input string req, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = A_DATA;
        #1 check(req, "receive head", bus_rdata, exp);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tx_take(input string req, input logic [7:0] exp);
        @(negedge clk);
        #1 check(req, "transmit head", txq_data, exp);
        txq_pop = 1'b1;
        @(negedge clk);
        txq_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        idle(2);
        peek(A_FSTAT, v); check("R11", "status after reset", v, 8'h84);
        check("R2", "status bits after reset", v, 8'h84);
        peek(A_FCFG, v);  check("R11", "config after reset", v, 8'h00);
        peek(A_EN, v);    check("R11", "enable after reset", v, 8'h00);
        peek(A_STAT, v);  check("R11", "flags after reset", v, 8'h01);
        check("R11", "irq after reset", {7'b0, irq}, 8'h00);
        check("R11", "txq_avail after reset", {7'b0, txq_avail}, 8'h00);
    endtask

    task automatic t_config();
        logic [7:0] v;
        wr(A_FCFG, 8'hFF);
        peek(A_FCFG, v); check("R3", "config readback all ones", v, 8'h8F);
        wr(A_FCFG, 8'h05);
        peek(A_FCFG, v); check("R3", "config readback field only", v, 8'h05);
        wr(A_EN, 8'hFE);
        peek(A_EN, v); check("R10", "enable readback", v, 8'h02);
        wr(A_EN, 8'h00);
        wr(A_FCFG, 8'h00);
    endtask

    task automatic t_tx_queue();
        logic [7:0] v;
        wr(A_FCFG, 8'h80);
        for (int i = 0; i < 16; i++) begin
            wr(A_DATA, 8'h10 + 8'(i));
            if (i == 7) begin
                peek(A_FSTAT, v); check("R5", "almost empty at 8", {7'b0, v[7]}, 8'h01);
            end
            if (i == 8) begin
                peek(A_FSTAT, v); check("R5", "almost empty at 9", {7'b0, v[7]}, 8'h00);
            end
        end
        peek(A_FSTAT, v); check("R2", "transmit full bit", {7'b0, v[4]}, 8'h01);
        wr(A_DATA, 8'hEE);
        wr(A_CLR, 8'h03);
        idle(1);
        peek(A_STAT, v); check("R7", "flags cleared while full", v, 8'h00);
        for (int i = 0; i < 16; i++) begin
            tx_take("R1", 8'h10 + 8'(i));
            if (i == 7) begin
                idle(1);
                peek(A_STAT, v); check("R6", "tx flag on level 8", {7'b0, v[0]}, 8'h01);
            end
        end
        idle(1);
        check("R1", "overflow byte dropped", {7'b0, txq_avail}, 8'h00);
        wr(A_FCFG, 8'h00);
        wr(A_DATA, 8'h77);
        peek(A_FSTAT, v); check("R5", "single mode one byte", {7'b0, v[7]}, 8'h00);
        tx_take("R1", 8'h77);
        peek(A_FSTAT, v); check("R5", "single mode empty", {7'b0, v[7]}, 8'h01);
    endtask

    task automatic t_rx_threshold();
        logic [7:0] v;
        wr(A_FCFG, 8'h08);
        wr(A_CLR, 8'h03);
        for (int i = 0; i < 8; i++) rx_put(8'h40 + 8'(i));
        idle(2);
        peek(A_FSTAT, v); check("R4", "no threshold at 8", {7'b0, v[3]}, 8'h00);
        peek(A_STAT, v);  check("R4", "no rx flag at 8", {7'b0, v[1]}, 8'h00);
        rx_put(8'h48);
        idle(2);
        peek(A_FSTAT, v); check("R4", "threshold at 9", {7'b0, v[3]}, 8'h01);
        peek(A_STAT, v);  check("R6", "rx flag at 9", {7'b0, v[1]}, 8'h01);
        for (int i = 0; i < 9; i++) rx_take("R1", 8'h40 + 8'(i));
        peek(A_FSTAT, v); check("R2", "receive empty bit", {7'b0, v[2]}, 8'h01);
        peek(A_STAT, v);  check("R6", "rx flag held after drain", {7'b0, v[1]}, 8'h01);
        wr(A_FCFG, 8'h0B);
        for (int i = 0; i < 11; i++) rx_put(8'h60 + 8'(i));
        idle(1);
        peek(A_FSTAT, v); check("R4", "field 3 no threshold at 11", {7'b0, v[3]}, 8'h00);
        rx_put(8'h6B);
        idle(1);
        peek(A_FSTAT, v); check("R4", "field 3 threshold at 12", {7'b0, v[3]}, 8'h01);
        for (int i = 0; i < 12; i++) rx_take("R1", 8'h60 + 8'(i));
        wr(A_FCFG, 8'h00);
        rx_put(8'h99);
        peek(A_FSTAT, v); check("R4", "single mode any byte", {7'b0, v[3]}, 8'h01);
        rx_take("R1", 8'h99);
    endtask

    task automatic t_force_mask();
        logic [7:0] v;
        wr(A_CLR, 8'h03);
        idle(1);
        peek(A_STAT, v); check("R7", "all cleared", v, 8'h00);
        wr(A_SET, 8'h02);
        peek(A_STAT, v); check("R8", "forced rx flag", v, 8'h02);
        check("R10", "masked irq", {7'b0, irq}, 8'h00);
        wr(A_EN, 8'h02);
        #1 check("R10", "enabled irq", {7'b0, irq}, 8'h01);
        wr(A_EN, 8'h01);
        #1 check("R10", "other source enabled", {7'b0, irq}, 8'h00);
        wr(A_EN, 8'h02);
        wr(A_SET, 8'h01);
        peek(A_STAT, v); check("R8", "forced tx flag", v, 8'h03);
        wr(A_CLR, 8'h01);
        peek(A_STAT, v); check("R7", "selective clear", v, 8'h02);
        #1 check("R10", "irq after selective clear", {7'b0, irq}, 8'h01);
        wr(A_CLR, 8'h02);
        peek(A_STAT, v); check("R7", "rx cleared", v, 8'h00);
        #1 check("R10", "irq after clear", {7'b0, irq}, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] v;
        wr(A_CLR, 8'h03);
        @(negedge clk);
        rxq_push = 1'b1; rxq_data = 8'h5A;
        @(negedge clk);
        rxq_push = 1'b0;
        bus_addr = A_CLR; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        peek(A_STAT, v); check("R9", "set wins over clear", {7'b0, v[1]}, 8'h01);
        wr(A_CLR, 8'h02);
        peek(A_STAT, v); check("R6", "level high no re-set", {7'b0, v[1]}, 8'h00);
        rx_take("R1", 8'h5A);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_tx_queue();
        t_rx_threshold();
        t_force_mask();
        t_race();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule